// File: doc/BRIEF.md
# Pixel Pair Packer

The block sits in front of a dual-lane display link. It accepts one 24-bit RGB pixel per input clock, or a full pixel pair per clock, and presents a 48-bit even/odd pair bus to the link. Three modes are available. In single mode it passes one pixel straight through. In dual mode it passes a pixel pair straight through. In split mode it joins two consecutive input pixels into one pair, which produces pairs at half the input rate. The DE, HSYNC and VSYNC timing controls travel with each pair.

In split mode a pair never spans a change of DE. When DE changes while a pixel is waiting for its partner, the waiting pixel goes out alone, with a zero odd half and a pad flag. The new pixel then starts a fresh pair. As a result, the first active pixel of every line lands in the even slot. The pair inherits the controls sampled with its even pixel.

An 18-bit depth option clears the two low bits of every colour. The mode and depth selections are captured only while reset is held. A lane-enable output tells the link whether the upper lanes and the second clock are in use.

Top module: `pixel_pair_packer`

## Requirements
- R1: While `rst` is high at a clock edge, every output after that edge is zero, including `out_vld`, `out_pad` and `out_wide`.
- R2: `mode_sel` and `six_sel` are sampled only at edges where `rst` is high. Changing them while out of reset has no effect on any output. Encoding: 0 is single, 1 is dual, 2 is split, and 3 acts as single.
- R3: Single mode has one register of latency. `out_even` carries the input pixel from `in_even`. `out_odd` is zero. `out_vld` is 1 on every cycle. `out_pad` is 0. `out_wide` is 0.
- R4: Dual mode has one register of latency. `out_even` carries `in_even` and `out_odd` carries `in_odd`. `out_vld` is 1 on every cycle. `out_wide` is 1.
- R5: In split mode the first pixel of a pair goes to `out_even` and the next pixel goes to `out_odd`. The pair appears in the cycle after the second pixel is sampled, with `out_vld` set to 1. On the cycle that follows a complete pair, `out_vld` is 0. `out_wide` is 1.
- R6: In split mode `out_de`, `out_hs` and `out_vs` carry the controls that were sampled with the even pixel of the pair. In single and dual mode they are the inputs delayed by one cycle.
- R7: In split mode the first pixel sampled after DE rises appears in `out_even`. This holds whatever number of blanking samples came before it.
- R8: In split mode, if `in_de` differs from the DE of a waiting pixel, the waiting pixel is emitted with `out_odd` equal to zero, `out_pad` equal to 1 and `out_vld` equal to 1. The current pixel then begins the next pair.
- R9: With `six_sel` = 1 captured, bits [1:0] of each 8-bit colour field are zero on both `out_even` and `out_odd`. Colour fields sit at bit 0, 8 and 16 of each pixel.
- R10: In split mode, `out_even`, `out_odd`, `out_de`, `out_hs` and `out_vs` keep their values on cycles where `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rst | input | 1 | Synchronous active-high reset; mode capture window |
| mode_sel | input | 2 | Mode: 0 single, 1 dual, 2 split |
| six_sel | input | 1 | 1 selects 18-bit depth |
| in_even | input | 24 | Input pixel (even pixel in dual mode) |
| in_odd | input | 24 | Odd input pixel, used in dual mode only |
| in_de | input | 1 | Data enable |
| in_hs | input | 1 | Horizontal sync |
| in_vs | input | 1 | Vertical sync |
| out_even | output | 24 | Even pixel of the pair |
| out_odd | output | 24 | Odd pixel of the pair |
| out_de | output | 1 | DE aligned to the pair |
| out_hs | output | 1 | HSYNC aligned to the pair |
| out_vs | output | 1 | VSYNC aligned to the pair |
| out_vld | output | 1 | Pair valid (half-rate enable in split mode) |
| out_pad | output | 1 | Pair holds one pixel and a zero odd half |
| out_wide | output | 1 | Upper lanes and second clock in use |

## Verification
The assertions check several properties on every cycle:
- the mode and depth selections stay frozen outside reset;
- a padded pair has a zero odd half;
- no odd data and no pad flag appear in single mode;
- 18-bit depth leaves the low colour bits clear;
- split-mode outputs hold between valid pairs;
- a complete split pair is never followed at once by another.

Only the bench scenarios can show the rest. These are which pixel lands in which slot, the controls that travel with each pair, and the restart of pairing at DE edges after both odd and even blanking or active runs. The bench compares against a queue-based model on every clock.

// File: rtl/pair_pkg.sv
package pair_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DUAL   = 2'd1,
    MODE_SPLIT  = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } ctl_t;
endpackage

// File: rtl/pair_trim.sv
module pair_trim #(
  parameter int COLOR_W  = 8,
  parameter int N_COLORS = 3,
  parameter int TRIM_W   = 2,
  localparam int PIX_W   = COLOR_W * N_COLORS
) (
  input  logic             trim_en,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PIX_W-1:0] pix_o
);
  for (genvar c = 0; c < N_COLORS; c++) begin : g_color
    localparam int BASE = c * COLOR_W;
    assign pix_o[BASE+COLOR_W-1:BASE+TRIM_W] = pix_i[BASE+COLOR_W-1:BASE+TRIM_W];
    assign pix_o[BASE+TRIM_W-1:BASE] = trim_en ? '0 : pix_i[BASE+TRIM_W-1:BASE];
  end
endmodule

// File: rtl/pair_join.sv
module pair_join
  import pair_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PIX_W-1:0] pix_i,
  input  ctl_t             ctl_i,
  output logic             emit_o,
  output logic             pad_o,
  output logic [PIX_W-1:0] even_o,
  output logic [PIX_W-1:0] odd_o,
  output ctl_t             ctl_o
);
  logic             have_q;
  logic [PIX_W-1:0] hold_pix_q;
  ctl_t             hold_ctl_q;
  logic             same_de;

  assign same_de = (ctl_i.de == hold_ctl_q.de);

  always_comb begin
    emit_o = have_q;
    pad_o  = have_q && !same_de;
    even_o = hold_pix_q;
    odd_o  = (have_q && same_de) ? pix_i : '0;
    ctl_o  = hold_ctl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q     <= 1'b0;
      hold_pix_q <= '0;
      hold_ctl_q <= '0;
    end else if (en) begin
      if (!have_q || !same_de) begin
        hold_pix_q <= pix_i;
        hold_ctl_q <= ctl_i;
        have_q     <= 1'b1;
      end else begin
        have_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pixel_pair_packer.sv
module pixel_pair_packer
  import pair_pkg::*;
#(
  parameter int COLOR_W  = 8,
  parameter int N_COLORS = 3,
  parameter int TRIM_W   = 2,
  localparam int PIX_W   = COLOR_W * N_COLORS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic             six_sel,
  input  logic [PIX_W-1:0] in_even,
  input  logic [PIX_W-1:0] in_odd,
  input  logic             in_de,
  input  logic             in_hs,
  input  logic             in_vs,
  output logic [PIX_W-1:0] out_even,
  output logic [PIX_W-1:0] out_odd,
  output logic             out_de,
  output logic             out_hs,
  output logic             out_vs,
  output logic             out_vld,
  output logic             out_pad,
  output logic             out_wide
);
  mode_e            mode_q;
  logic             six_q;
  logic [PIX_W-1:0] even_t, odd_t;
  ctl_t             ctl_in, ctl_q, j_ctl;
  logic             j_emit, j_pad;
  logic [PIX_W-1:0] j_even, j_odd;

  assign ctl_in = '{de: in_de, hs: in_hs, vs: in_vs};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_e'(mode_sel);
      six_q  <= six_sel;
    end
  end

  pair_trim #(.COLOR_W(COLOR_W), .N_COLORS(N_COLORS), .TRIM_W(TRIM_W)) u_trim_even (
    .trim_en(six_q), .pix_i(in_even), .pix_o(even_t)
  );

  pair_trim #(.COLOR_W(COLOR_W), .N_COLORS(N_COLORS), .TRIM_W(TRIM_W)) u_trim_odd (
    .trim_en(six_q), .pix_i(in_odd), .pix_o(odd_t)
  );

  pair_join #(.PIX_W(PIX_W)) u_join (
    .clk(clk), .rst(rst), .en(mode_q == MODE_SPLIT),
    .pix_i(even_t), .ctl_i(ctl_in),
    .emit_o(j_emit), .pad_o(j_pad), .even_o(j_even), .odd_o(j_odd), .ctl_o(j_ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_even <= '0;
      out_odd  <= '0;
      ctl_q    <= '0;
      out_vld  <= 1'b0;
      out_pad  <= 1'b0;
      out_wide <= 1'b0;
    end else begin
      out_wide <= (mode_q == MODE_DUAL) || (mode_q == MODE_SPLIT);
      case (mode_q)
        MODE_DUAL: begin
          out_even <= even_t;
          out_odd  <= odd_t;
          ctl_q    <= ctl_in;
          out_vld  <= 1'b1;
          out_pad  <= 1'b0;
        end
        MODE_SPLIT: begin
          out_vld <= j_emit;
          out_pad <= j_pad;
          if (j_emit) begin
            out_even <= j_even;
            out_odd  <= j_odd;
            ctl_q    <= j_ctl;
          end
        end
        default: begin
          out_even <= even_t;
          out_odd  <= '0;
          ctl_q    <= ctl_in;
          out_vld  <= 1'b1;
          out_pad  <= 1'b0;
        end
      endcase
    end
  end

  assign out_de = ctl_q.de;
  assign out_hs = ctl_q.hs;
  assign out_vs = ctl_q.vs;
endmodule

// File: rtl/pixel_pair_packer_chk.sv
module pixel_pair_packer_chk
  import pair_pkg::*;
#(
  parameter int COLOR_W  = 8,
  parameter int N_COLORS = 3,
  parameter int TRIM_W   = 2,
  localparam int PIX_W   = COLOR_W * N_COLORS
) (
  input logic             clk,
  input logic             rst,
  input mode_e            mode_q,
  input logic             six_q,
  input logic [PIX_W-1:0] out_even,
  input logic [PIX_W-1:0] out_odd,
  input logic             out_de,
  input logic             out_vld,
  input logic             out_pad
);
  logic low_any;
  always_comb begin
    low_any = 1'b0;
    for (int c = 0; c < N_COLORS; c++) begin
      for (int b = 0; b < TRIM_W; b++) begin
        low_any = low_any | out_even[c*COLOR_W+b] | out_odd[c*COLOR_W+b];
      end
    end
  end

  // R2: selections frozen outside reset
  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($stable(mode_q) && $stable(six_q)));

  // R8: padded pair carries zero odd half and is valid
  a_r8_pad_odd_zero: assert property (@(posedge clk) disable iff (rst)
    out_pad |-> (out_vld && out_odd == '0));

  // R3: single mode never drives odd data or pad
  a_r3_single_no_odd: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SINGLE) |-> (out_odd == '0 && !out_pad));

  // R9: 18-bit depth clears low colour bits
  a_r9_low_bits_clear: assert property (@(posedge clk) disable iff (rst)
    six_q |-> !low_any);

  // R10: split outputs hold while not valid
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SPLIT && !out_vld) |-> ($stable(out_even) && $stable(out_odd) && $stable(out_de)));

  // R5: a complete split pair is followed by an idle cycle
  a_r5_pair_then_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SPLIT && out_vld && !out_pad) |=> !out_vld);
endmodule

bind pixel_pair_packer pixel_pair_packer_chk #(
  .COLOR_W(COLOR_W), .N_COLORS(N_COLORS), .TRIM_W(TRIM_W)
) u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .six_q(six_q),
  .out_even(out_even), .out_odd(out_odd), .out_de(out_de),
  .out_vld(out_vld), .out_pad(out_pad)
);

// File: tb/pixel_pair_packer_tb.sv
module pixel_pair_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 24;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] mode_sel;
  logic six_sel;
  logic [PW-1:0] in_even, in_odd;
  logic in_de, in_hs, in_vs;
  logic [PW-1:0] out_even, out_odd;
  logic out_de, out_hs, out_vs, out_vld, out_pad, out_wide;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_pair_packer u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .six_sel(six_sel),
    .in_even(in_even), .in_odd(in_odd), .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
    .out_even(out_even), .out_odd(out_odd), .out_de(out_de), .out_hs(out_hs),
    .out_vs(out_vs), .out_vld(out_vld), .out_pad(out_pad), .out_wide(out_wide)
  );

  typedef struct { logic [PW-1:0] px; logic de, hs, vs; } ent_t;
  ent_t pend[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_mode;
  bit m_six;
  logic [PW-1:0] e_even, e_odd;
  logic e_de, e_hs, e_vs, e_vld, e_pad, e_wide;

  function automatic logic [PW-1:0] trim(input logic [PW-1:0] p, input bit en);
    logic [PW-1:0] r = p;
    if (en) for (int i = 0; i < PW; i++) if ((i % 8) < 2) r[i] = 1'b0;
    return r;
  endfunction

  task automatic model_edge();
    ent_t cur;
    if (rst) begin
      m_mode = int'(mode_sel); m_six = six_sel;
      e_even = '0; e_odd = '0; {e_de, e_hs, e_vs, e_vld, e_pad, e_wide} = '0;
      pend.delete();
      return;
    end
    cur.px = trim(in_even, m_six); cur.de = in_de; cur.hs = in_hs; cur.vs = in_vs;
    e_wide = (m_mode == 1 || m_mode == 2);
    if (m_mode == 2) begin
      if (pend.size() == 0) begin
        pend.push_back(cur); e_vld = 0; e_pad = 0;
      end else if (pend[0].de == cur.de) begin
        e_even = pend[0].px; e_odd = cur.px;
        {e_de, e_hs, e_vs} = {pend[0].de, pend[0].hs, pend[0].vs};
        e_vld = 1; e_pad = 0; void'(pend.pop_front());
      end else begin
        e_even = pend[0].px; e_odd = '0;
        {e_de, e_hs, e_vs} = {pend[0].de, pend[0].hs, pend[0].vs};
        e_vld = 1; e_pad = 1; void'(pend.pop_front()); pend.push_back(cur);
      end
    end else begin
      e_even = cur.px;
      e_odd = (m_mode == 1) ? trim(in_odd, m_six) : '0;
      {e_de, e_hs, e_vs} = {cur.de, cur.hs, cur.vs};
      e_vld = 1; e_pad = 0;
    end
  endtask

  task automatic step(input string req, input logic de, input logic hs, input logic vs);
    in_even = PW'($urandom()); in_odd = PW'($urandom());
    in_de = de; in_hs = hs; in_vs = vs;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if ({out_even, out_odd, out_de, out_hs, out_vs, out_vld, out_pad, out_wide} !==
        {e_even, e_odd, e_de, e_hs, e_vs, e_vld, e_pad, e_wide}) begin
      errors++;
      $display("FAIL %s: actual even=%h odd=%h de/hs/vs=%b%b%b vld=%b pad=%b wide=%b expected even=%h odd=%h de/hs/vs=%b%b%b vld=%b pad=%b wide=%b",
        req, out_even, out_odd, out_de, out_hs, out_vs, out_vld, out_pad, out_wide,
        e_even, e_odd, e_de, e_hs, e_vs, e_vld, e_pad, e_wide);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input bit s);
    rst = 1; mode_sel = m; six_sel = s;
    step("R1", 0, 0, 0);
    step("R1", 0, 0, 0);
    rst = 0;
  endtask

  task automatic line(input string req, input int nblank, input int nact, input bit vs);
    for (int i = 0; i < nblank; i++) step(req, 0, (i < 2), vs);
    for (int i = 0; i < nact; i++) step(req, 1, 0, vs);
  endtask

  initial begin
    in_even = '0; in_odd = '0; in_de = 0; in_hs = 0; in_vs = 0;
    @(negedge clk);
    // R1 reset, R3 single mode, R2 mode_sel change ignored outside reset
    do_reset(2'd0, 0);
    for (int i = 0; i < 10; i++) step("R3", i[0], i[1], 0);
    mode_sel = 2'd2; six_sel = 1;
    for (int i = 0; i < 10; i++) step("R2", 1, 0, 0);
    // R4 dual mode with control pass-through R6
    do_reset(2'd1, 0);
    for (int i = 0; i < 12; i++) step("R4", i[0], i[2], i[1]);
    // R5 R7 R8 R6 R10 split mode across odd/even runs
    do_reset(2'd2, 0);
    line("R7", 3, 6, 0);
    line("R8", 4, 5, 0);
    line("R5", 2, 8, 1);
    line("R8", 1, 1, 0);
    line("R10", 5, 3, 1);
    step("R6", 0, 1, 1);
    // R9 18-bit depth in split and dual
    do_reset(2'd2, 1);
    line("R9", 3, 7, 0);
    do_reset(2'd1, 1);
    for (int i = 0; i < 8; i++) step("R9", 1, 0, 0);
    // reserved encoding acts as single
    do_reset(2'd3, 0);
    for (int i = 0; i < 6; i++) step("R2", 1, 0, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule